// File: doc/BRIEF.md
# Banked UART Register Interface

This block is the host-facing control section of a 16550-compatible UART that carries an extra register bank. A byte-wide register bus with word-spaced offsets (0x00 to 0x1C, four bytes apart) reaches three overlapping banks. The normal bank holds data, interrupt enable, interrupt identification and FIFO control, line control, modem control, line status, modem status and a scratch byte. Setting line-control bit 7 swaps the first two offsets over to the 16-bit baud divisor. Writing the exact value 0xBF into line control brings up an enhanced bank. That bank holds an enhanced-feature byte and four software flow-control characters (two XON, two XOFF).

The block drives configuration outputs to the rest of the UART: FIFO enable, DMA mode, trigger levels and one-cycle FIFO clear pulses, together with line control, modem control, divisor, enhanced features and the flow characters. Data writes become a push strobe toward the transmit FIFO and data reads become a pop strobe toward the receive FIFO. From the receiver, transmitter, flow and modem status inputs, the block builds the line status and modem status bytes. It ranks the pending interrupt sources into one identification code and raises a registered interrupt line.

Top module: `uart_regbank`

## Requirements
- R1: After reset, line control, interrupt enable and the enhanced-feature register read 0x00, the divisor output is 0x0000 and the identification register reads 0x01.
- R2: While line control is neither bit-7-set nor 0xBF, the following registers can be written and read back: interrupt enable (0x04), line control (0x0C), modem control (0x10) and scratch (0x1C). A write to 0x00 gives a one-cycle `tx_push` with `tx_data` equal to the written byte. A read of 0x00 returns `rx_data`.
- R3: While line-control bit 7 is set, offset 0x00 reaches divisor bits 7:0 and offset 0x04 reaches divisor bits 15:8. The interrupt enable register is left untouched.
- R4: Only when line control equals exactly 0xBF are these registers reached: enhanced features at 0x08, XON1 at 0x10, XON2 at 0x14, XOFF1 at 0x18 and XOFF2 at 0x1C. Modem control and scratch keep their values. With line control at 0xBE, offset 0x08 still reads identification.
- R5: A write to 0x08 in a non-0xBF bank stores FIFO enable (bit 0), DMA mode (bit 3), TX trigger (bits 5:4) and RX trigger (bits 7:6). Bits 1 and 2 give one-cycle `rx_clr` / `tx_clr` pulses in the cycle after the write and are not stored.
- R6: Identification bit 0 is 1 when nothing is pending. The type codes are line error 0x06, RX timeout 0x0C, RX data 0x04, TX empty 0x02, modem 0x00, XOFF 0x10 and flow change 0x20. Bits 7:6 both equal the FIFO enable.
- R7: Only the highest-priority pending source is reported. The order is line error, then RX timeout, then RX data, then TX empty, then XOFF, then flow change, then modem status.
- R8: Each source is gated by its interrupt enable bit: bit 0 for RX data and timeout, bit 1 for TX empty, bit 2 for line error, bit 3 for modem, bit 5 for XOFF and bit 6 for flow change.
- R9: TX empty becomes pending when `tx_room` rises, or when enable bit 1 is set while `tx_room` is high. It is cleared by an identification read that reports it, or by a data write.
- R10: Line status bits are: 0 `rx_ready`, 1 overrun, 2 parity, 3 framing, 4 break, 5 `tx_room`, 6 `tx_idle`, 7 `rx_fifo_err`. Bits 1 to 4 latch their input pulses and are cleared by a line status read.
- R11: Modem status bits 3:0 latch `modem_delta` pulses and bits 7:4 show `modem_lines`. A modem status read clears bits 3:0.
- R12: Modem control bit 6 changes only while enhanced-feature bit 4 is set.
- R13: `irq_out` goes high one cycle after any enabled source becomes pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | ADDR_W | Byte offset, word aligned |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid the cycle after `bus_rd` |
| tx_data | output | 8 | Byte for the transmit FIFO |
| tx_push | output | 1 | Transmit FIFO push pulse |
| rx_data | input | 8 | Head of the receive FIFO |
| rx_pop | output | 1 | Receive FIFO pop pulse |
| fifo_en | output | 1 | FIFO enable |
| dma_mode | output | 1 | DMA mode select |
| tx_trig | output | 2 | TX trigger level |
| rx_trig | output | 2 | RX trigger level |
| rx_clr | output | 1 | Receive FIFO clear pulse |
| tx_clr | output | 1 | Transmit FIFO clear pulse |
| lcr_out | output | 8 | Line control |
| mcr_out | output | 8 | Modem control |
| divisor | output | 16 | Baud divisor |
| efr_out | output | 8 | Enhanced features |
| xon1 | output | 8 | First XON character |
| xon2 | output | 8 | Second XON character |
| xoff1 | output | 8 | First XOFF character |
| xoff2 | output | 8 | Second XOFF character |
| rx_ready | input | 1 | Receive FIFO holds data |
| rx_timeout | input | 1 | Receive character timeout |
| rx_oe | input | 1 | Overrun pulse |
| rx_pe | input | 1 | Parity error pulse |
| rx_fe | input | 1 | Framing error pulse |
| rx_bi | input | 1 | Break pulse |
| rx_fifo_err | input | 1 | Some entry in the RX FIFO has an error |
| tx_room | input | 1 | Transmit holding/FIFO has room |
| tx_idle | input | 1 | Transmitter fully empty |
| xoff_seen | input | 1 | XOFF character received (level) |
| flow_change | input | 1 | Flow-control state changed (level) |
| modem_delta | input | 4 | Modem line change pulses |
| modem_lines | input | 4 | Current modem line levels |
| irq_out | output | 1 | Interrupt request |

## Verification
The assertions assume that a bus master never raises `bus_wr` and `bus_rd` in the same cycle. They also assume it never writes the FIFO control offset in two consecutive cycles; without that, a clear pulse could legally stretch to two cycles. The line status read-clear property takes for granted that error pulses can arrive during a read, and it only judges reads with no new error in that cycle. The stimulus issues each bus access as a one-cycle strobe followed by an idle cycle, and it changes status inputs only between accesses. This keeps every access inside those assumptions.

// File: rtl/uart_regbank_pkg.sv
package uart_regbank_pkg;

  localparam logic [7:0] BANK_KEY = 8'hBF;

  typedef enum logic [3:0] {
    SEL_DATA, SEL_DLL, SEL_DLH, SEL_IER, SEL_IDENT, SEL_EFR, SEL_LCR, SEL_MCR,
    SEL_LSR, SEL_MSR, SEL_SCR, SEL_XON1, SEL_XON2, SEL_XOFF1, SEL_XOFF2, SEL_NONE
  } reg_sel_e;

  // identification codes, bits 5:0 of the byte
  localparam logic [5:0] ID_NONE  = 6'h01;
  localparam logic [5:0] ID_LINE  = 6'h06;
  localparam logic [5:0] ID_TMO   = 6'h0C;
  localparam logic [5:0] ID_RXD   = 6'h04;
  localparam logic [5:0] ID_THR   = 6'h02;
  localparam logic [5:0] ID_XOFF  = 6'h10;
  localparam logic [5:0] ID_FLOW  = 6'h20;
  localparam logic [5:0] ID_MDM   = 6'h00;

  // enable bit positions
  localparam int EN_RX   = 0;
  localparam int EN_THR  = 1;
  localparam int EN_LINE = 2;
  localparam int EN_MDM  = 3;
  localparam int EN_XOFF = 5;
  localparam int EN_FLOW = 6;

  localparam int EFR_ENH = 4;

  typedef struct packed {
    logic [1:0] rx_trig;
    logic [1:0] tx_trig;
    logic       dma;
    logic       en;
  } fifo_cfg_t;

endpackage

// File: rtl/uart_rb_decode.sv
module uart_rb_decode
  import uart_regbank_pkg::*;
#(
  parameter int IDX_W = 3
) (
  input  logic [IDX_W-1:0] idx,
  input  logic [7:0]       lcr,
  output reg_sel_e         sel
);

  logic key_bank;
  logic dlab;

  assign key_bank = (lcr == BANK_KEY);
  assign dlab     = lcr[7];

  always_comb begin
    case (idx)
      IDX_W'(0): sel = dlab     ? SEL_DLL   : SEL_DATA;
      IDX_W'(1): sel = dlab     ? SEL_DLH   : SEL_IER;
      IDX_W'(2): sel = key_bank ? SEL_EFR   : SEL_IDENT;
      IDX_W'(3): sel = SEL_LCR;
      IDX_W'(4): sel = key_bank ? SEL_XON1  : SEL_MCR;
      IDX_W'(5): sel = key_bank ? SEL_XON2  : SEL_LSR;
      IDX_W'(6): sel = key_bank ? SEL_XOFF1 : SEL_MSR;
      IDX_W'(7): sel = key_bank ? SEL_XOFF2 : SEL_SCR;
      default:   sel = SEL_NONE;
    endcase
  end

endmodule

// File: rtl/uart_rb_irq.sv
module uart_rb_irq
  import uart_regbank_pkg::*;
#(
  parameter int NSRC = 7
) (
  input  logic [7:0] ier,
  input  logic       line_err,
  input  logic       rx_timeout,
  input  logic       rx_ready,
  input  logic       thr_pend,
  input  logic       xoff_seen,
  input  logic       flow_change,
  input  logic       mdm_delta,
  input  logic       fifo_en,
  output logic [7:0] ident,
  output logic       active
);

  // index 0 is the highest priority
  localparam logic [5:0] CODES [NSRC] = '{ID_LINE, ID_TMO, ID_RXD, ID_THR, ID_XOFF, ID_FLOW, ID_MDM};

  logic [NSRC-1:0] req;
  logic [5:0]      code;

  assign req[0] = line_err    & ier[EN_LINE];
  assign req[1] = rx_timeout  & ier[EN_RX];
  assign req[2] = rx_ready    & ier[EN_RX];
  assign req[3] = thr_pend    & ier[EN_THR];
  assign req[4] = xoff_seen   & ier[EN_XOFF];
  assign req[5] = flow_change & ier[EN_FLOW];
  assign req[6] = mdm_delta   & ier[EN_MDM];

  always_comb begin
    code = ID_NONE;
    for (int i = NSRC - 1; i >= 0; i--) begin
      if (req[i]) code = CODES[i];
    end
  end

  assign active = |req;
  assign ident  = {fifo_en, fifo_en, code};

endmodule

// File: rtl/uart_rb_status.sv
module uart_rb_status #(
  parameter int ERR_W = 4,
  parameter int MDM_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [ERR_W-1:0] err_in,
  input  logic             lsr_rd,
  input  logic             rx_ready,
  input  logic             tx_room,
  input  logic             tx_idle,
  input  logic             rx_fifo_err,
  input  logic [MDM_W-1:0] mdm_delta_in,
  input  logic [MDM_W-1:0] mdm_lines,
  input  logic             msr_rd,
  output logic [7:0]       lsr,
  output logic [7:0]       msr,
  output logic [ERR_W-1:0] err_sticky,
  output logic             delta_any
);

  logic [MDM_W-1:0] delta_q;

  // a new event in the reading cycle survives the clear
  always_ff @(posedge clk) begin
    if (rst) begin
      err_sticky <= '0;
      delta_q    <= '0;
    end else begin
      err_sticky <= (lsr_rd ? '0 : err_sticky) | err_in;
      delta_q    <= (msr_rd ? '0 : delta_q) | mdm_delta_in;
    end
  end

  assign lsr       = {rx_fifo_err, tx_idle, tx_room, err_sticky, rx_ready};
  assign msr       = {mdm_lines, delta_q};
  assign delta_any = |delta_q;

endmodule

// File: rtl/uart_regbank.sv
module uart_regbank
  import uart_regbank_pkg::*;
#(
  parameter int ADDR_W = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [7:0]        bus_wdata,
  output logic [7:0]        bus_rdata,
  output logic [7:0]        tx_data,
  output logic              tx_push,
  input  logic [7:0]        rx_data,
  output logic              rx_pop,
  output logic              fifo_en,
  output logic              dma_mode,
  output logic [1:0]        tx_trig,
  output logic [1:0]        rx_trig,
  output logic              rx_clr,
  output logic              tx_clr,
  output logic [7:0]        lcr_out,
  output logic [7:0]        mcr_out,
  output logic [15:0]       divisor,
  output logic [7:0]        efr_out,
  output logic [7:0]        xon1,
  output logic [7:0]        xon2,
  output logic [7:0]        xoff1,
  output logic [7:0]        xoff2,
  input  logic              rx_ready,
  input  logic              rx_timeout,
  input  logic              rx_oe,
  input  logic              rx_pe,
  input  logic              rx_fe,
  input  logic              rx_bi,
  input  logic              rx_fifo_err,
  input  logic              tx_room,
  input  logic              tx_idle,
  input  logic              xoff_seen,
  input  logic              flow_change,
  input  logic [3:0]        modem_delta,
  input  logic [3:0]        modem_lines,
  output logic              irq_out
);

  localparam int IDX_W = ADDR_W - 2;

  reg_sel_e   sel;
  logic [7:0] ier_q;
  logic [7:0] scr_q;
  fifo_cfg_t  fcfg_q;
  logic       thr_pend;
  logic       room_q;
  logic [7:0] ident;
  logic       irq_active;
  logic [7:0] lsr_byte;
  logic [7:0] msr_byte;
  logic [3:0] lsr_err;
  logic       delta_any;
  logic       lsr_rd;
  logic       msr_rd;
  logic       ident_ack;
  logic       thr_set;
  logic       data_wr;
  logic [7:0] rd_mux;

  uart_rb_decode #(.IDX_W(IDX_W)) i_decode (
    .idx (bus_addr[ADDR_W-1:2]),
    .lcr (lcr_out),
    .sel (sel)
  );

  assign lsr_rd    = bus_rd & (sel == SEL_LSR);
  assign msr_rd    = bus_rd & (sel == SEL_MSR);
  assign ident_ack = bus_rd & (sel == SEL_IDENT) & (ident[5:0] == ID_THR);
  assign data_wr   = bus_wr & (sel == SEL_DATA);
  assign thr_set   = (tx_room & ~room_q) |
                     (bus_wr & (sel == SEL_IER) & bus_wdata[EN_THR] & ~ier_q[EN_THR] & tx_room);

  uart_rb_status #(.ERR_W(4), .MDM_W(4)) i_status (
    .clk          (clk),
    .rst          (rst),
    .err_in       ({rx_bi, rx_fe, rx_pe, rx_oe}),
    .lsr_rd       (lsr_rd),
    .rx_ready     (rx_ready),
    .tx_room      (tx_room),
    .tx_idle      (tx_idle),
    .rx_fifo_err  (rx_fifo_err),
    .mdm_delta_in (modem_delta),
    .mdm_lines    (modem_lines),
    .msr_rd       (msr_rd),
    .lsr          (lsr_byte),
    .msr          (msr_byte),
    .err_sticky   (lsr_err),
    .delta_any    (delta_any)
  );

  uart_rb_irq #(.NSRC(7)) i_irq (
    .ier         (ier_q),
    .line_err    (|lsr_err),
    .rx_timeout  (rx_timeout),
    .rx_ready    (rx_ready),
    .thr_pend    (thr_pend),
    .xoff_seen   (xoff_seen),
    .flow_change (flow_change),
    .mdm_delta   (delta_any),
    .fifo_en     (fcfg_q.en),
    .ident       (ident),
    .active      (irq_active)
  );

  // register writes
  always_ff @(posedge clk) begin
    if (rst) begin
      lcr_out <= '0;
      mcr_out <= '0;
      ier_q   <= '0;
      scr_q   <= '0;
      divisor <= '0;
      efr_out <= '0;
      xon1    <= '0;
      xon2    <= '0;
      xoff1   <= '0;
      xoff2   <= '0;
      fcfg_q  <= '0;
      tx_data <= '0;
    end else if (bus_wr) begin
      case (sel)
        SEL_DATA:  tx_data       <= bus_wdata;
        SEL_DLL:   divisor[7:0]  <= bus_wdata;
        SEL_DLH:   divisor[15:8] <= bus_wdata;
        SEL_IER:   ier_q         <= bus_wdata;
        SEL_IDENT: fcfg_q        <= '{rx_trig: bus_wdata[7:6], tx_trig: bus_wdata[5:4],
                                      dma: bus_wdata[3], en: bus_wdata[0]};
        SEL_EFR:   efr_out       <= bus_wdata;
        SEL_LCR:   lcr_out       <= bus_wdata;
        SEL_MCR:   mcr_out       <= {bus_wdata[7],
                                     efr_out[EFR_ENH] ? bus_wdata[6] : mcr_out[6],
                                     bus_wdata[5:0]};
        SEL_SCR:   scr_q         <= bus_wdata;
        SEL_XON1:  xon1          <= bus_wdata;
        SEL_XON2:  xon2          <= bus_wdata;
        SEL_XOFF1: xoff1         <= bus_wdata;
        SEL_XOFF2: xoff2         <= bus_wdata;
        default: ;
      endcase
    end
  end

  // strobes and pending flag
  always_ff @(posedge clk) begin
    if (rst) begin
      tx_push  <= 1'b0;
      rx_pop   <= 1'b0;
      rx_clr   <= 1'b0;
      tx_clr   <= 1'b0;
      room_q   <= 1'b0;
      thr_pend <= 1'b0;
      irq_out  <= 1'b0;
    end else begin
      tx_push <= data_wr;
      rx_pop  <= bus_rd & (sel == SEL_DATA);
      rx_clr  <= bus_wr & (sel == SEL_IDENT) & bus_wdata[1];
      tx_clr  <= bus_wr & (sel == SEL_IDENT) & bus_wdata[2];
      room_q  <= tx_room;
      irq_out <= irq_active;
      if (thr_set)
        thr_pend <= 1'b1;
      else if (ident_ack | data_wr)
        thr_pend <= 1'b0;
    end
  end

  // read path
  always_comb begin
    case (sel)
      SEL_DATA:  rd_mux = rx_data;
      SEL_DLL:   rd_mux = divisor[7:0];
      SEL_DLH:   rd_mux = divisor[15:8];
      SEL_IER:   rd_mux = ier_q;
      SEL_IDENT: rd_mux = ident;
      SEL_EFR:   rd_mux = efr_out;
      SEL_LCR:   rd_mux = lcr_out;
      SEL_MCR:   rd_mux = mcr_out;
      SEL_LSR:   rd_mux = lsr_byte;
      SEL_MSR:   rd_mux = msr_byte;
      SEL_SCR:   rd_mux = scr_q;
      SEL_XON1:  rd_mux = xon1;
      SEL_XON2:  rd_mux = xon2;
      SEL_XOFF1: rd_mux = xoff1;
      SEL_XOFF2: rd_mux = xoff2;
      default:   rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)
      bus_rdata <= '0;
    else if (bus_rd)
      bus_rdata <= rd_mux;
  end

  assign fifo_en  = fcfg_q.en;
  assign dma_mode = fcfg_q.dma;
  assign tx_trig  = fcfg_q.tx_trig;
  assign rx_trig  = fcfg_q.rx_trig;

endmodule

// File: rtl/uart_regbank_chk.sv
module uart_regbank_chk #(
  parameter int ADDR_W = 5
) (
  input logic              clk,
  input logic              rst,
  input logic              bus_wr,
  input logic              bus_rd,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [7:0]        bus_wdata,
  input logic              rx_clr,
  input logic              irq_out,
  input logic [7:0]        lcr_out,
  input logic [7:0]        mcr_out,
  input logic [7:0]        efr_out,
  input logic [7:0]        ier_q,
  input logic [3:0]        lsr_err,
  input logic              rx_oe,
  input logic              rx_pe,
  input logic              rx_fe,
  input logic              rx_bi
);

  localparam int IDX_W = ADDR_W - 2;

  logic [IDX_W-1:0] idx;
  logic             key_bank;

  assign idx      = bus_addr[ADDR_W-1:2];
  assign key_bank = (lcr_out == 8'hBF);

  // R5: a clear pulse follows a FIFO-control write with bit 1 set
  p_clr_origin_r5: assert property (@(posedge clk) disable iff (rst)
    rx_clr |-> $past(bus_wr && idx == IDX_W'(2) && !key_bank && bus_wdata[1]));

  // R5: clear pulses last a single cycle
  p_clr_single_r5: assert property (@(posedge clk) disable iff (rst)
    rx_clr |=> !rx_clr);

  // R4: the key bank routes offset 0x08 to the enhanced-feature register
  p_efr_bank_r4: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && idx == IDX_W'(2) && key_bank) |=> efr_out == $past(bus_wdata));

  // R8: no enabled source means no request
  p_quiet_r8: assert property (@(posedge clk) disable iff (rst)
    $past(ier_q == 8'h00) |-> !irq_out);

  // R10: a line status read with no new event empties the sticky bits
  p_lsr_rc_r10: assert property (@(posedge clk) disable iff (rst)
    $past(bus_rd && idx == IDX_W'(5) && !key_bank && !(rx_oe || rx_pe || rx_fe || rx_bi))
      |-> lsr_err == 4'h0);

  // R12: modem control bit 6 is locked while enhanced functions are off
  p_mcr6_lock_r12: assert property (@(posedge clk) disable iff (rst)
    !efr_out[4] |=> $stable(mcr_out[6]));

endmodule

bind uart_regbank uart_regbank_chk #(.ADDR_W(ADDR_W)) i_chk (
  .clk       (clk),
  .rst       (rst),
  .bus_wr    (bus_wr),
  .bus_rd    (bus_rd),
  .bus_addr  (bus_addr),
  .bus_wdata (bus_wdata),
  .rx_clr    (rx_clr),
  .irq_out   (irq_out),
  .lcr_out   (lcr_out),
  .mcr_out   (mcr_out),
  .efr_out   (efr_out),
  .ier_q     (ier_q),
  .lsr_err   (lsr_err),
  .rx_oe     (rx_oe),
  .rx_pe     (rx_pe),
  .rx_fe     (rx_fe),
  .rx_bi     (rx_bi)
);

// File: tb/test_uart_regbank.sv
`timescale 1ns/1ps
module test_uart_regbank;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [4:0]  bus_addr = '0;
  logic        bus_wr = 1'b0;
  logic        bus_rd = 1'b0;
  logic [7:0]  bus_wdata = '0;
  logic [7:0]  bus_rdata;
  logic [7:0]  tx_data;
  logic        tx_push;
  logic [7:0]  rx_data = 8'hA7;
  logic        rx_pop;
  logic        fifo_en, dma_mode, rx_clr, tx_clr, irq_out;
  logic [1:0]  tx_trig, rx_trig;
  logic [7:0]  lcr_out, mcr_out, efr_out, xon1, xon2, xoff1, xoff2;
  logic [15:0] divisor;
  logic        rx_ready = 0, rx_timeout = 0, rx_oe = 0, rx_pe = 0, rx_fe = 0, rx_bi = 0;
  logic        rx_fifo_err = 0, tx_room = 0, tx_idle = 0, xoff_seen = 0, flow_change = 0;
  logic [3:0]  modem_delta = '0, modem_lines = '0;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #10 clk = ~clk;

  uart_regbank #(.ADDR_W(5)) i_uart_regbank (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .tx_data(tx_data), .tx_push(tx_push),
    .rx_data(rx_data), .rx_pop(rx_pop), .fifo_en(fifo_en), .dma_mode(dma_mode),
    .tx_trig(tx_trig), .rx_trig(rx_trig), .rx_clr(rx_clr), .tx_clr(tx_clr),
    .lcr_out(lcr_out), .mcr_out(mcr_out), .divisor(divisor), .efr_out(efr_out),
    .xon1(xon1), .xon2(xon2), .xoff1(xoff1), .xoff2(xoff2), .rx_ready(rx_ready),
    .rx_timeout(rx_timeout), .rx_oe(rx_oe), .rx_pe(rx_pe), .rx_fe(rx_fe), .rx_bi(rx_bi),
    .rx_fifo_err(rx_fifo_err), .tx_room(tx_room), .tx_idle(tx_idle),
    .xoff_seen(xoff_seen), .flow_change(flow_change), .modem_delta(modem_delta),
    .modem_lines(modem_lines), .irq_out(irq_out)
  );

  typedef struct packed {
    logic       rd;
    logic [4:0] addr;
    logic [7:0] data;
    logic [3:0] req;
  } vec_t;

  localparam int NVEC = 34;
  localparam vec_t TBL [NVEC] = '{
    '{1'b1, 5'h0C, 8'h00, 4'd1},  // R1 line control
    '{1'b1, 5'h04, 8'h00, 4'd1},  // R1 enable
    '{1'b1, 5'h08, 8'h01, 4'd1},  // R1 identification
    '{1'b0, 5'h1C, 8'h5A, 4'd2},  // R2 scratch
    '{1'b1, 5'h1C, 8'h5A, 4'd2},
    '{1'b0, 5'h10, 8'h03, 4'd2},  // R2 modem control
    '{1'b1, 5'h10, 8'h03, 4'd2},
    '{1'b1, 5'h00, 8'hA7, 4'd2},  // R2 receive data
    '{1'b0, 5'h0C, 8'h83, 4'd3},  // R3 open divisor
    '{1'b0, 5'h00, 8'h1C, 4'd3},
    '{1'b0, 5'h04, 8'h12, 4'd3},
    '{1'b1, 5'h00, 8'h1C, 4'd3},
    '{1'b1, 5'h04, 8'h12, 4'd3},
    '{1'b0, 5'h0C, 8'h03, 4'd3},
    '{1'b1, 5'h04, 8'h00, 4'd3},  // R3 enable untouched
    '{1'b1, 5'h0C, 8'h03, 4'd2},
    '{1'b0, 5'h0C, 8'hBF, 4'd4},  // R4 key bank
    '{1'b0, 5'h08, 8'h10, 4'd4},
    '{1'b0, 5'h10, 8'h11, 4'd4},
    '{1'b0, 5'h14, 8'h13, 4'd4},
    '{1'b0, 5'h18, 8'h91, 4'd4},
    '{1'b0, 5'h1C, 8'h93, 4'd4},
    '{1'b1, 5'h08, 8'h10, 4'd4},
    '{1'b1, 5'h10, 8'h11, 4'd4},
    '{1'b1, 5'h14, 8'h13, 4'd4},
    '{1'b1, 5'h18, 8'h91, 4'd4},
    '{1'b1, 5'h1C, 8'h93, 4'd4},
    '{1'b1, 5'h00, 8'h1C, 4'd3},  // R3 bit 7 set in key value
    '{1'b0, 5'h0C, 8'h03, 4'd4},
    '{1'b1, 5'h10, 8'h03, 4'd4},  // R4 modem control kept
    '{1'b1, 5'h1C, 8'h5A, 4'd4},  // R4 scratch kept
    '{1'b0, 5'h0C, 8'hBE, 4'd4},  // R4 near-miss key
    '{1'b1, 5'h08, 8'h01, 4'd4},
    '{1'b0, 5'h0C, 8'h03, 4'd4}
  };

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [4:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [4:0] a, output logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_rd = 1'b1;
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  task automatic read_expect(input logic [4:0] a, input logic [7:0] e, input string req);
    logic [7:0] v;
    bus_read(a, v);
    check(v == e, req, v, e);
  endtask

  task automatic settle();
    @(negedge clk);
  endtask

  initial begin
    int cyc = 0;
    while (!done) begin
      @(posedge clk);
      cyc++;
      if (cyc > 20000) begin
        errors++;
        checks++;
        $display("FAIL watchdog actual=%0d expected=done", cyc);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    check(divisor == 16'h0000 && efr_out == 8'h00, "R1 reset outputs", {divisor, efr_out}, 0);

    for (int i = 0; i < NVEC; i++) begin
      if (TBL[i].rd) begin
        logic [7:0] v;
        bus_read(TBL[i].addr, v);
        check(v == TBL[i].data, $sformatf("R%0d table step %0d", TBL[i].req, i), v, TBL[i].data);
      end else begin
        bus_write(TBL[i].addr, TBL[i].data);
      end
    end
    check(divisor == 16'h121C, "R3 divisor port", divisor, 16'h121C);
    check(xoff2 == 8'h93 && xon1 == 8'h11, "R4 flow char ports", {xon1, xoff2}, 16'h1193);

    // R12: bit 6 locked without enhanced enable
    bus_write(5'h0C, 8'hBF); bus_write(5'h08, 8'h00); bus_write(5'h0C, 8'h03);
    bus_write(5'h10, 8'h40);
    read_expect(5'h10, 8'h00, "R12 locked");
    bus_write(5'h0C, 8'hBF); bus_write(5'h08, 8'h10); bus_write(5'h0C, 8'h03);
    bus_write(5'h10, 8'h40);
    read_expect(5'h10, 8'h40, "R12 unlocked");

    // R5: FIFO control fields and clear pulses
    bus_write(5'h08, 8'hC7);
    check(rx_clr && tx_clr, "R5 clear pulses", {rx_clr, tx_clr}, 2'b11);
    check(fifo_en && !dma_mode && tx_trig == 2'd0 && rx_trig == 2'd3, "R5 fields a",
          {fifo_en, dma_mode, tx_trig, rx_trig}, 6'b100011);
    settle();
    check(!rx_clr && !tx_clr, "R5 pulse width", {rx_clr, tx_clr}, 0);
    bus_write(5'h08, 8'h39);
    check(!rx_clr && fifo_en && dma_mode && tx_trig == 2'd3 && rx_trig == 2'd0, "R5 fields b",
          {rx_clr, fifo_en, dma_mode, tx_trig, rx_trig}, 7'b0111100);
    read_expect(5'h08, 8'hC1, "R6 mirror idle");

    // interrupt ranking
    bus_write(5'h04, 8'h6F);
    @(negedge clk); modem_delta = 4'b0001;
    @(negedge clk); modem_delta = 4'b0000;
    read_expect(5'h08, 8'hC0, "R6 modem code");
    check(irq_out, "R13 irq raised", irq_out, 1);
    flow_change = 1'b1; settle();
    read_expect(5'h08, 8'hE0, "R7 flow over modem");
    xoff_seen = 1'b1; settle();
    read_expect(5'h08, 8'hD0, "R7 xoff over flow");
    tx_room = 1'b1; settle();
    read_expect(5'h08, 8'hC2, "R9 tx empty set");
    read_expect(5'h08, 8'hD0, "R9 acked by read");
    tx_room = 1'b0; settle();
    tx_room = 1'b1; settle();
    bus_write(5'h00, 8'h55);
    check(tx_push && tx_data == 8'h55, "R2 push", {tx_push, tx_data}, 9'h155);
    read_expect(5'h08, 8'hD0, "R9 cleared by data write");
    rx_ready = 1'b1; settle();
    read_expect(5'h08, 8'hC4, "R7 rx data");
    rx_timeout = 1'b1; settle();
    read_expect(5'h08, 8'hCC, "R7 timeout");
    @(negedge clk); rx_pe = 1'b1;
    @(negedge clk); rx_pe = 1'b0;
    read_expect(5'h08, 8'hC6, "R7 line error top");

    // R10 line status
    read_expect(5'h14, 8'h25, "R10 status byte");
    read_expect(5'h14, 8'h21, "R10 read clears");
    read_expect(5'h08, 8'hCC, "R10 line source gone");

    // R8 gating
    bus_write(5'h04, 8'h00);
    read_expect(5'h08, 8'hC1, "R8 all gated");
    check(!irq_out, "R8 irq low", irq_out, 0);
    bus_write(5'h04, 8'h01);
    read_expect(5'h08, 8'hCC, "R8 rx only");

    // R11 modem status
    modem_lines = 4'hA; settle();
    read_expect(5'h18, 8'hA1, "R11 delta latched");
    read_expect(5'h18, 8'hA0, "R11 read clears");

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule